// File: doc/BRIEF.md
# I2C Target with Event Flags

This block answers as a target on a two-wire I2C bus under one programmable 7-bit address. SCL and SDA come in as raw line levels. They pass through a synchroniser clocked by the system clock, and START and STOP are recognised as SDA edges while SCL is high. The block drives the bus through two open-drain enables. When `sda_oe` or `scl_oe` is 1, the pad pulls that line low.

A host sees five byte-wide registers:

| Offset | Register |
|---|---|
| 0 | Control |
| 1 | Event status |
| 2 | Interrupt mask |
| 3 | Own address |
| 4 | Shared data port |

The host clears event flags by writing zeros to them. The host services each byte through the data port. Until the host does, the block holds SCL low so the bus controller waits. A level interrupt combines the status flags that the mask allows.

Top module: `i2c_target_flags`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, and neither line is driven.
- R2: The block ACKs an address byte only when all three hold: control bit 2 (enable) is 1, the own-address register (offset 3) is nonzero, and the upper seven bits of the byte equal it. A match sets status bit 0. No other 7-bit address is acknowledged, and none sets bit 0.
- R3: The block acknowledges nothing, not even a general call, while the own address is 0 or control bit 2 is 0.
- R4: Address 0 with the write direction is ACKed only when control bit 1 (general-call enable) is also set. Such a match sets status bit 6. Address 0 with the read direction is never ACKed.
- R5: In a write transfer, each data byte is ACKed, appears at the data port (offset 4), and sets status bit 1.
- R6: While control bit 0 is 1, every received data byte is answered with NACK, but it is still stored and flagged. Address bytes are still ACKed. The next data byte after the bit is cleared is ACKed again.
- R7: A read match sets status bits 5 and 3. A byte written to the data port is shifted out MSB first, and SDA changes only while SCL is low. Status bit 2 is set in each controller acknowledge slot. Status bit 3 is set again only when the controller ACKs.
- R8: SCL is held low after every target ACK slot and after every controller-ACKed transmit byte. It is released once the host reads the data port in a write transfer, or writes it in a read transfer.
- R9: Every STOP on the bus sets status bit 4, including one ending a transfer to another address.
- R10: Writing the status register (offset 1) clears each bit written 0 and leaves each bit written 1 unchanged.
- R11: `irq` is 1 exactly when some status bit and the matching interrupt-mask bit (offset 2, same layout) are both 1.
- R12: A START seen in the middle of a transfer restarts address reception, so a repeated START can turn a write into a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on data port only) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Combined masked event interrupt |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Some properties are checked on every cycle. Event flags fall only after a status write. The block starts to stretch SCL, or to pull SDA low, only while the synchronised SCL is low. `irq` stays low whenever the mask is empty or no flag is set. The bench's scenarios cover the rest: the address-decode sweep over all 128 addresses, general-call gating, the NACK override, MSB-first transmit data and controller-ACK handling, the release of stretching by data-port access, and repeated START. Each of these needs a full bus transaction to be observed.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int unsigned REG_AW  = 3;
    localparam int unsigned FLAGS_N = 7;
    localparam int unsigned CTRL_N  = 4;

    // status / interrupt-mask bit positions
    localparam int unsigned FL_ADDR   = 0;
    localparam int unsigned FL_RXD    = 1;
    localparam int unsigned FL_TXD    = 2;
    localparam int unsigned FL_EMPTY  = 3;
    localparam int unsigned FL_STOP   = 4;
    localparam int unsigned FL_TXMODE = 5;
    localparam int unsigned FL_GCALL  = 6;

    // control bit positions
    localparam int unsigned CT_NACK = 0;
    localparam int unsigned CT_GC   = 1;
    localparam int unsigned CT_EN   = 2;

    // register offsets
    localparam logic [REG_AW-1:0] OFS_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] OFS_STAT = 3'd1;
    localparam logic [REG_AW-1:0] OFS_IEN  = 3'd2;
    localparam logic [REG_AW-1:0] OFS_OWN  = 3'd3;
    localparam logic [REG_AW-1:0] OFS_DATA = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ACK_A, ST_RX, ST_ACK_R, ST_TX, ST_ACK_T, ST_WAIT
    } eng_st_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // STAGES synchroniser flops plus one history flop per line
    logic [STAGES:0] scl_d, scl_q, sda_d, sda_q;
    logic            scl_prev, sda_prev;

    always_comb begin
        scl_d = {scl_q[STAGES-1:0], scl_i};
        sda_d = {sda_q[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_o     = scl_q[STAGES-1];
    assign sda_o     = sda_q[STAGES-1];
    assign scl_prev  = scl_q[STAGES];
    assign sda_prev  = sda_q[STAGES];
    assign scl_rise  = scl_o & ~scl_prev;
    assign scl_fall  = ~scl_o & scl_prev;
    assign start_det = scl_o & scl_prev & sda_prev & ~sda_o;
    assign stop_det  = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               active,
    input  logic               gc_en,
    input  logic [DW-2:0]      own_addr,
    input  logic               force_nack,
    input  logic               host_wr,
    input  logic [DW-1:0]      host_wdata,
    input  logic               host_rd,
    output logic               sda_oe,
    output logic               scl_oe,
    output logic [FLAGS_N-1:0] ev_set,
    output logic               mode_we,
    output logic               mode_val,
    output logic               rx_we,
    output logic [DW-1:0]      rx_byte
);
    localparam int unsigned CW = $clog2(DW + 1);

    typedef struct packed {
        eng_st_e       st;
        logic [DW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          hold;
        logic          rdir;
        logic          acked;
        logic          nack;
    } eng_t;

    eng_t          d, q;
    logic [DW-2:0] addr_rx;
    logic          rw_rx, hit_own, hit_gc;

    assign addr_rx = q.sh[DW-1:1];
    assign rw_rx   = q.sh[0];
    assign hit_own = active && (addr_rx == own_addr);
    assign hit_gc  = active && gc_en && (addr_rx == '0) && !rw_rx;

    always_comb begin
        d        = q;
        ev_set   = '0;
        mode_we  = 1'b0;
        mode_val = 1'b0;
        rx_we    = 1'b0;
        unique case (q.st)
            ST_ADDR: begin
                if (scl_rise) begin
                    d.sh  = {q.sh[DW-2:0], sda_s};
                    d.cnt = q.cnt + CW'(1);
                end else if (scl_fall && q.cnt == CW'(DW)) begin
                    if (hit_own || hit_gc) begin
                        d.st               = ST_ACK_A;
                        d.rdir             = rw_rx;
                        ev_set[FL_ADDR]    = 1'b1;
                        ev_set[FL_GCALL]   = hit_gc;
                        ev_set[FL_EMPTY]   = rw_rx;
                        mode_we            = 1'b1;
                        mode_val           = rw_rx;
                    end else begin
                        d.st = ST_WAIT;
                    end
                end
            end
            ST_ACK_A: begin
                if (scl_fall) begin
                    d.st   = q.rdir ? ST_TX : ST_RX;
                    d.hold = 1'b1;
                    d.cnt  = '0;
                end
            end
            ST_RX: begin
                if (scl_rise) begin
                    d.sh  = {q.sh[DW-2:0], sda_s};
                    d.cnt = q.cnt + CW'(1);
                end else if (scl_fall && q.cnt == CW'(DW)) begin
                    rx_we          = 1'b1;
                    ev_set[FL_RXD] = 1'b1;
                    d.st           = ST_ACK_R;
                    d.nack         = force_nack;
                    d.cnt          = '0;
                end
            end
            ST_ACK_R: begin
                if (scl_fall) begin
                    d.st   = ST_RX;
                    d.hold = 1'b1;
                end
            end
            ST_TX: begin
                if (scl_fall && !q.hold) begin
                    d.sh  = {q.sh[DW-2:0], 1'b0};
                    d.cnt = q.cnt + CW'(1);
                    if (q.cnt == CW'(DW - 1)) begin
                        d.st  = ST_ACK_T;
                        d.cnt = '0;
                    end
                end
            end
            ST_ACK_T: begin
                if (scl_rise) begin
                    d.acked        = ~sda_s;
                    ev_set[FL_TXD] = 1'b1;
                end else if (scl_fall) begin
                    if (q.acked) begin
                        d.st             = ST_TX;
                        d.hold           = 1'b1;
                        ev_set[FL_EMPTY] = 1'b1;
                    end else begin
                        d.st = ST_WAIT;
                    end
                end
            end
            default: ;
        endcase

        // host service releases the stretched clock
        if (q.hold && q.st == ST_RX && host_rd) begin
            d.hold = 1'b0;
        end
        if (q.hold && q.st == ST_TX && host_wr) begin
            d.hold = 1'b0;
            d.sh   = host_wdata;
            d.cnt  = '0;
        end

        // bus conditions override everything
        if (start_det) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.sh   = '0;
            d.hold = 1'b0;
        end else if (stop_det) begin
            d.st            = ST_IDLE;
            d.hold          = 1'b0;
            ev_set[FL_STOP] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rx_byte = q.sh;
    assign scl_oe  = q.hold;
    assign sda_oe  = (q.st == ST_ACK_A)
                   | (q.st == ST_ACK_R && !q.nack)
                   | (q.st == ST_TX && !q.hold && !q.sh[DW-1]);
endmodule

// File: rtl/i2c_target_flags.sv
module i2c_target_flags
    import i2c_tgt_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe
);
    localparam int unsigned ADDR_W = DATA_W - 1;

    typedef struct packed {
        logic [CTRL_N-1:0]  ctrl;
        logic [FLAGS_N-1:0] stat;
        logic [FLAGS_N-1:0] ien;
        logic [ADDR_W-1:0]  own;
        logic [DATA_W-1:0]  data;
    } regs_t;

    regs_t              d, q;
    logic               scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [FLAGS_N-1:0] ev_set;
    logic               mode_we, mode_val, rx_we, host_wr, host_rd, active;
    logic [DATA_W-1:0]  rx_byte;
    logic [FLAGS_N-1:0] stat_view, ien_view;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign host_wr = reg_wr && (reg_addr == OFS_DATA);
    assign host_rd = reg_rd && (reg_addr == OFS_DATA);
    assign active  = q.ctrl[CT_EN] && (q.own != '0);

    i2c_tgt_engine #(.DW(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .active(active), .gc_en(q.ctrl[CT_GC]), .own_addr(q.own),
        .force_nack(q.ctrl[CT_NACK]), .host_wr(host_wr), .host_wdata(reg_wdata),
        .host_rd(host_rd), .sda_oe(sda_oe), .scl_oe(scl_oe), .ev_set(ev_set),
        .mode_we(mode_we), .mode_val(mode_val), .rx_we(rx_we), .rx_byte(rx_byte)
    );

    always_comb begin
        d = q;
        if (reg_wr) begin
            unique case (reg_addr)
                OFS_CTRL: d.ctrl = reg_wdata[CTRL_N-1:0];
                OFS_STAT: d.stat = q.stat & reg_wdata[FLAGS_N-1:0];
                OFS_IEN:  d.ien  = reg_wdata[FLAGS_N-1:0];
                OFS_OWN:  d.own  = reg_wdata[ADDR_W-1:0];
                OFS_DATA: d.data = reg_wdata;
                default: ;
            endcase
        end
        d.stat = d.stat | ev_set;
        if (mode_we) begin
            d.stat[FL_TXMODE] = mode_val;
        end
        if (rx_we) begin
            d.data = rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = DATA_W'(q.ctrl);
            OFS_STAT: reg_rdata = DATA_W'(q.stat);
            OFS_IEN:  reg_rdata = DATA_W'(q.ien);
            OFS_OWN:  reg_rdata = DATA_W'(q.own);
            OFS_DATA: reg_rdata = q.data;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq       = |(q.stat & q.ien);
    assign stat_view = q.stat;
    assign ien_view  = q.ien;
endmodule

// File: rtl/i2c_target_flags_chk.sv
module i2c_target_flags_chk
    import i2c_tgt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [REG_AW-1:0]  reg_addr,
    input logic               irq,
    input logic [FLAGS_N-1:0] stat,
    input logic [FLAGS_N-1:0] ien,
    input logic               scl_oe,
    input logic               sda_oe,
    input logic               scl_s
);
    localparam logic [FLAGS_N-1:0] CLR_MASK = ~(FLAGS_N'(1) << FL_TXMODE);

    // R10: an event flag only drops after a status-register write
    assert_clear_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stat) & ~stat & CLR_MASK)) |-> $past(reg_wr && reg_addr == OFS_STAT));

    // R11: an empty mask keeps the interrupt low
    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    // R11: the interrupt needs at least one pending flag
    assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != '0));

    // R8: stretching begins only while SCL is already low
    assert_stretch_on_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> !$past(scl_s));

    // R7: SDA is pulled low only while SCL is low
    assert_sda_on_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));
endmodule

bind i2c_target_flags i2c_target_flags_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .irq(irq),
    .stat(stat_view), .ien(ien_view), .scl_oe(scl_oe), .sda_oe(sda_oe), .scl_s(scl_s)
);

// File: tb/tb_i2c_target_flags.sv
module tb_i2c_target_flags;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       scl_line, sda_line;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    i2c_target_flags dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_c(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic m_start;
        m_sda = 1'b1; wait_c(Q);
        m_scl = 1'b1; wait_c(Q);
        m_sda = 1'b0; wait_c(Q);
        m_scl = 1'b0; wait_c(Q);
    endtask

    task automatic m_stop;
        m_sda = 1'b0; wait_c(Q);
        m_scl = 1'b1; wait_c(Q);
        m_sda = 1'b1; wait_c(Q);
    endtask

    task automatic m_bit(input logic b, output logic s);
        m_sda = b; wait_c(Q);
        m_scl = 1'b1; wait_c(1);
        while (!scl_line) wait_c(1);
        wait_c(Q); s = sda_line;
        wait_c(Q); m_scl = 1'b0; wait_c(Q);
    endtask

    task automatic m_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) m_bit(b[i], s);
        m_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic m_rdbyte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, s);
            b[i] = s;
        end
        m_bit(~give_ack, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic       ack;
        logic [7:0] wbytes [4];
        wbytes[0] = 8'h3C; wbytes[1] = 8'hA5; wbytes[2] = 8'h00; wbytes[3] = 8'hFF;

        wait_c(3);
        rst_n = 1'b1;
        wait_c(2);

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 8'h00, "R1 reset register", v, 0);
        end
        chk(irq == 1'b0 && scl_oe == 1'b0 && sda_oe == 1'b0, "R1 reset outputs",
            {irq, scl_oe, sda_oe}, 0);

        // R3: enable clear -> no response
        wr(3, 8'h5A); wr(0, 8'h00);
        m_start; m_byte({7'h5A, 1'b0}, ack); m_stop;
        chk(!ack, "R3 disabled nack", ack, 0);
        rd(1, v);
        chk(v[0] == 1'b0, "R3 no addr flag", v, 0);
        chk(v[4] == 1'b1, "R9 stop while disabled", v[4], 1);
        // R3: own address zero disables even general call
        wr(3, 8'h00); wr(0, 8'h06);
        m_start; m_byte(8'h00, ack); m_stop;
        chk(!ack, "R3 own zero nack", ack, 0);

        // R2 / R9: sweep all addresses
        wr(3, 8'h5A); wr(0, 8'h04);
        for (int a = 0; a < 128; a++) begin
            wr(1, 8'h00);
            m_start; m_byte({7'(a), 1'b0}, ack);
            chk(ack == (a == 8'h5A), "R2 address ack", ack, (a == 8'h5A));
            if (ack) rd(4, v);
            m_stop;
            rd(1, v);
            chk(v[0] == (a == 8'h5A), "R2 address flag", v[0], (a == 8'h5A));
            chk(v[4] == 1'b1, "R9 stop flag", v[4], 1);
        end

        // R5 / R8 / R10 / R11: write transfer
        wr(1, 8'h00); wr(2, 8'h02);
        m_start; m_byte({7'h5A, 1'b0}, ack);
        chk(ack, "R2 write addr ack", ack, 1);
        chk(scl_oe == 1'b1, "R8 stretch after addr", scl_oe, 1);
        rd(1, v);
        chk(v == 8'h01, "R5 status after addr", v, 8'h01);
        rd(4, v);
        wait_c(2);
        chk(scl_oe == 1'b0, "R8 release on dummy read", scl_oe, 0);
        foreach (wbytes[k]) begin
            m_byte(wbytes[k], ack);
            chk(ack, "R5 data ack", ack, 1);
            chk(scl_oe == 1'b1, "R8 stretch after byte", scl_oe, 1);
            chk(irq == 1'b1, "R11 irq on rx flag", irq, 1);
            rd(4, v);
            chk(v == wbytes[k], "R5 data port", v, wbytes[k]);
            wait_c(2);
            chk(scl_oe == 1'b0, "R8 release on read", scl_oe, 0);
            wr(1, 8'hFD);
            rd(1, v);
            chk(v == 8'h01, "R10 clear by zero", v, 8'h01);
            chk(irq == 1'b0, "R11 irq cleared", irq, 0);
        end
        m_stop;
        wr(2, 8'h00);

        // R6: forced NACK
        wr(0, 8'h05);
        m_start; m_byte({7'h5A, 1'b0}, ack);
        chk(ack, "R6 addr still acked", ack, 1);
        rd(4, v);
        m_byte(8'h11, ack);
        chk(!ack, "R6 nack first", ack, 0);
        rd(4, v);
        chk(v == 8'h11, "R6 byte stored", v, 8'h11);
        m_byte(8'h22, ack);
        chk(!ack, "R6 nack persists", ack, 0);
        wr(0, 8'h04);
        rd(4, v);
        m_byte(8'h33, ack);
        chk(ack, "R6 ack after clear", ack, 1);
        rd(4, v);
        m_stop;

        // R7: read transfer
        wr(1, 8'h00);
        m_start; m_byte({7'h5A, 1'b1}, ack);
        chk(ack, "R7 read addr ack", ack, 1);
        rd(1, v);
        chk(v == 8'h29, "R7 status after read match", v, 8'h29);
        chk(scl_oe == 1'b1, "R8 stretch before tx load", scl_oe, 1);
        wr(1, 8'h00);
        wr(4, 8'hC3);
        m_rdbyte(1'b1, v);
        chk(v == 8'hC3, "R7 tx byte msb first", v, 8'hC3);
        rd(1, v);
        chk(v == 8'h0C, "R7 flags after acked byte", v, 8'h0C);
        chk(scl_oe == 1'b1, "R8 stretch after tx ack", scl_oe, 1);
        wr(1, 8'h00);
        wr(4, 8'h5E);
        m_rdbyte(1'b0, v);
        chk(v == 8'h5E, "R7 second tx byte", v, 8'h5E);
        rd(1, v);
        chk(v == 8'h04, "R7 no empty after nack", v, 8'h04);
        m_stop;
        rd(1, v);
        chk(v == 8'h14, "R9 stop after read", v, 8'h14);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R7 lines released", {scl_oe, sda_oe}, 0);

        // R4: general call
        wr(1, 8'h00);
        m_start; m_byte(8'h00, ack); m_stop;
        chk(!ack, "R4 gc disabled nack", ack, 0);
        rd(1, v);
        chk(v[6] == 1'b0, "R4 no gc flag", v[6], 0);
        wr(0, 8'h06); wr(1, 8'h00);
        m_start; m_byte(8'h00, ack);
        chk(ack, "R4 gc ack", ack, 1);
        rd(4, v); m_stop;
        rd(1, v);
        chk(v[6] == 1'b1 && v[0] == 1'b1, "R4 gc flag", v, 8'h51);
        m_start; m_byte(8'h01, ack); m_stop;
        chk(!ack, "R4 gc read nack", ack, 0);

        // R12: repeated start turns write into read
        m_start; m_byte({7'h5A, 1'b0}, ack);
        rd(4, v);
        m_byte(8'h77, ack);
        chk(ack, "R12 write before restart", ack, 1);
        rd(4, v);
        wr(1, 8'h00);
        m_start; m_byte({7'h5A, 1'b1}, ack);
        chk(ack, "R12 restart addr ack", ack, 1);
        rd(1, v);
        chk(v == 8'h29, "R12 read mode after restart", v, 8'h29);
        wr(4, 8'h81);
        m_rdbyte(1'b0, v);
        chk(v == 8'h81, "R12 byte after restart", v, 8'h81);
        m_stop;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule